// File: doc/BRIEF.md
# Write Strobe Window Checker

This block watches the write side of an AXI4 memory-mapped link on a 32-bit data bus. When a write address handshake is accepted, it records the start byte address, the beat size and the beat count. From these it works out, beat by beat, which byte lanes the manager may enable. On a misaligned start, the first beat's window begins at the lane of the start byte, so the lanes below that byte are excluded. Every later beat gets the whole size-aligned window that follows.

On each accepted data beat, the checker compares the manager's write strobe with that window. It also compares the last-beat marker with its own beat counter. Each kind of fault raises its own one-cycle error pulse. Strobes that enable fewer lanes than the window allows are always legal. The block follows one incrementing burst at a time, so it is meant to sit beside a bus port as a protocol monitor. It only observes the handshakes and never drives them.

Top module: `wstrb_window_check`

## Requirements
- R1: While reset is held and in the first cycle after it, `strbErr` and `lastErr` are low and `legalLanes` is 4'b0000. A value of 0 on `legalLanes` means no burst is open.
- R2: An address handshake with `awBurst` = 2'b01 (incrementing) while no burst is open opens a burst from the next cycle. The first beat's `legalLanes` then has bit n set for every lane n from `awAddr[1:0]` up to the top lane of the 2^`awSize`-byte window holding that address. For example, start 0x09 with size 2 gives 4'b1110, and start 0x09 with size 1 gives 4'b0010.
- R3: After each accepted beat, the window moves to the next 2^`awSize`-byte aligned block, and the lane index wraps modulo 4. Start 0x09 with size 1 gives 0010, 1100, 0011, 1100. An aligned start with size 2 gives 1111 on every beat.
- R4: `strbErr` pulses high for exactly one cycle, in the cycle after an accepted beat of an open burst whose `wStrb` has any bit set outside `legalLanes`. For example, 4'b0111 against a start of 0x09 with size 2 raises it.
- R5: A `wStrb` that enables only lanes within `legalLanes`, including 4'b0000, raises no `strbErr`.
- R6: `lastErr` pulses high for one cycle, in the cycle after an accepted beat with `wLast` high whose index is below `awLen`. The burst stays open and the beat count continues.
- R7: The burst takes exactly `awLen`+1 beats. `lastErr` also pulses after beat `awLen` when that beat lacks `wLast`. After beat `awLen` the burst closes whatever `wLast` was, and `legalLanes` returns to 0.
- R8: An address handshake while a burst is open is ignored, and the current burst's windows continue unchanged.
- R9: An address handshake whose `awBurst` is not 2'b01 opens no burst. Data beats accepted while no burst is open raise neither error.
- R10: Size 0 gives a single-lane window that walks up one lane per beat. Start 0x02 gives 0100, 1000, 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| awValid | input | 1 | Address channel valid, observed |
| awReady | input | 1 | Address channel ready, observed |
| awAddr | input | ADDR_W | Start byte address |
| awSize | input | SIZE_W | Log2 of bytes per beat |
| awLen | input | LEN_W | Beat count minus one |
| awBurst | input | 2 | Burst type; 2'b01 is incrementing |
| wValid | input | 1 | Data channel valid, observed |
| wReady | input | 1 | Data channel ready, observed |
| wStrb | input | DATA_BYTES | Byte-lane write enables of the beat |
| wLast | input | 1 | Manager's last-beat marker |
| strbErr | output | 1 | One-cycle pulse: strobe set outside the window |
| lastErr | output | 1 | One-cycle pulse: last-beat marker misplaced |
| legalLanes | output | DATA_BYTES | Legal lane window of the next beat; 0 when no burst is open |

## Verification
The assertions assume that every accepted address handshake carries a size no wider than the 4-byte bus. The stimulus respects this by using only sizes 0, 1 and 2. The address and data phases of a burst never share a cycle: the first beat is driven only after the address handshake has completed. Non-incrementing burst types appear only to show that they open no burst.

// File: rtl/wstrb_pkg.sv
package wstrb_pkg;
  // Strobes from the burst control to the lane datapath
  typedef struct packed {
    logic load;     // latch start lane and size of a new burst
    logic advance;  // step the window to the next beat
    logic open;     // a burst is being tracked
  } ctlStrobes_t;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/wstrb_lane_dp.sv
module wstrb_lane_dp
  import wstrb_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int SIZE_W     = 3,
  localparam int LANE_W    = $clog2(DATA_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           ctl,
  input  logic [LANE_W-1:0]     startLane,
  input  logic [SIZE_W-1:0]     startSize,
  input  logic [DATA_BYTES-1:0] beatStrb,
  output logic [DATA_BYTES-1:0] legalLanes,
  output logic                  strbOutside
);
  localparam int SPAN_W = LANE_W + 1;

  logic [LANE_W-1:0] laneQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [SPAN_W-1:0] beatBytes;
  logic [SPAN_W-1:0] alignedLane;
  logic [SPAN_W-1:0] topLane;
  logic [SPAN_W-1:0] nextLane;

  always_comb begin
    beatBytes   = SPAN_W'(1) << sizeQ;
    alignedLane = {1'b0, laneQ} & ~(beatBytes - SPAN_W'(1));
    topLane     = alignedLane + beatBytes - SPAN_W'(1);
    nextLane    = alignedLane + beatBytes;
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    assign legalLanes[g] = ctl.open
                         && (SPAN_W'(g) >= {1'b0, laneQ})
                         && (SPAN_W'(g) <= topLane);
  end

  assign strbOutside = |(beatStrb & ~legalLanes);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ <= '0;
      sizeQ <= '0;
    end else if (ctl.load) begin
      laneQ <= startLane;
      sizeQ <= startSize;
    end else if (ctl.advance) begin
      laneQ <= nextLane[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/wstrb_burst_ctl.sv
module wstrb_burst_ctl
  import wstrb_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             awFire,
  input  logic             awIncr,
  input  logic [LEN_W-1:0] awLen,
  input  logic             wFire,
  input  logic             wLast,
  input  logic             strbOutside,
  output ctlStrobes_t      ctl,
  output logic             strbErr,
  output logic             lastErr
);
  logic             busyQ;
  logic [LEN_W-1:0] beatQ;
  logic [LEN_W-1:0] lenQ;
  logic             finalBeat;

  assign finalBeat   = (beatQ == lenQ);
  assign ctl.load    = !busyQ && awFire && awIncr;
  assign ctl.advance = busyQ && wFire;
  assign ctl.open    = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      beatQ   <= '0;
      lenQ    <= '0;
      strbErr <= 1'b0;
      lastErr <= 1'b0;
    end else begin
      strbErr <= ctl.advance && strbOutside;
      lastErr <= ctl.advance && (wLast != finalBeat);
      if (ctl.load) begin
        busyQ <= 1'b1;
        beatQ <= '0;
        lenQ  <= awLen;
      end else if (ctl.advance) begin
        if (finalBeat) busyQ <= 1'b0;
        else           beatQ <= beatQ + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/wstrb_window_check.sv
module wstrb_window_check
  import wstrb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int LEN_W      = 8,
  parameter int SIZE_W     = 3,
  localparam int LANE_W    = $clog2(DATA_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  awValid,
  input  logic                  awReady,
  input  logic [ADDR_W-1:0]     awAddr,
  input  logic [SIZE_W-1:0]     awSize,
  input  logic [LEN_W-1:0]      awLen,
  input  logic [1:0]            awBurst,
  input  logic                  wValid,
  input  logic                  wReady,
  input  logic [DATA_BYTES-1:0] wStrb,
  input  logic                  wLast,
  output logic                  strbErr,
  output logic                  lastErr,
  output logic [DATA_BYTES-1:0] legalLanes
);
  ctlStrobes_t ctl;
  logic        strbOutside;

  wstrb_burst_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .awFire      (awValid && awReady),
    .awIncr      (awBurst == BURST_INCR),
    .awLen       (awLen),
    .wFire       (wValid && wReady),
    .wLast       (wLast),
    .strbOutside (strbOutside),
    .ctl         (ctl),
    .strbErr     (strbErr),
    .lastErr     (lastErr)
  );

  wstrb_lane_dp #(.DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .startLane   (awAddr[LANE_W-1:0]),
    .startSize   (awSize),
    .beatStrb    (wStrb),
    .legalLanes  (legalLanes),
    .strbOutside (strbOutside)
  );
endmodule

// File: rtl/wstrb_window_check_sva.sv
module wstrb_window_check_sva #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int LEN_W      = 8,
  parameter int SIZE_W     = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  awValid,
  input logic                  awReady,
  input logic [ADDR_W-1:0]     awAddr,
  input logic [SIZE_W-1:0]     awSize,
  input logic [LEN_W-1:0]      awLen,
  input logic [1:0]            awBurst,
  input logic                  wValid,
  input logic                  wReady,
  input logic [DATA_BYTES-1:0] wStrb,
  input logic                  wLast,
  input logic                  strbErr,
  input logic                  lastErr,
  input logic [DATA_BYTES-1:0] legalLanes
);
  localparam int MAX_SIZE = $clog2(DATA_BYTES);

  // R4
  strb_err_after_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbErr |-> $past(wValid && wReady));

  // R6
  last_err_after_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastErr |-> $past(wValid && wReady));

  // R2
  burst_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady && awBurst == 2'b01 && legalLanes == '0) |=> (legalLanes != '0));

  // R5
  subset_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && wReady && legalLanes != '0 && (wStrb & ~legalLanes) == '0) |=> !strbErr);

  // R9
  idle_beat_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && wReady && legalLanes == '0) |=> (!strbErr && !lastErr));

  // R2
  size_contract_chk: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady) |-> (int'(awSize) <= MAX_SIZE));
endmodule

bind wstrb_window_check wstrb_window_check_sva #(
  .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
) u_sva (
  .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady),
  .awAddr(awAddr), .awSize(awSize), .awLen(awLen), .awBurst(awBurst),
  .wValid(wValid), .wReady(wReady), .wStrb(wStrb), .wLast(wLast),
  .strbErr(strbErr), .lastErr(lastErr), .legalLanes(legalLanes)
);

// File: tb/wstrb_window_check_bench.sv
`timescale 1ns/1ps
module wstrb_window_check_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        awValid = 1'b0;
  logic        awReady = 1'b1;
  logic [31:0] awAddr = '0;
  logic [2:0]  awSize = '0;
  logic [7:0]  awLen = '0;
  logic [1:0]  awBurst = 2'b01;
  logic        wValid = 1'b0;
  logic        wReady = 1'b1;
  logic [3:0]  wStrb = '0;
  logic        wLast = 1'b0;
  logic        strbErr;
  logic        lastErr;
  logic [3:0]  legalLanes;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic  expStrb;
    logic  expLast;
    string tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #4 clk = ~clk;

  wstrb_window_check u_wstrb_window_check (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReady),
    .awAddr(awAddr), .awSize(awSize), .awLen(awLen), .awBurst(awBurst),
    .wValid(wValid), .wReady(wReady), .wStrb(wStrb), .wLast(wLast),
    .strbErr(strbErr), .lastErr(lastErr), .legalLanes(legalLanes)
  );

  function automatic logic [3:0] laneWin(int addr, int size, int k);
    int bytes = 1 << size;
    int base  = addr & ~(bytes - 1);
    int beat  = (k == 0) ? addr : base + k * bytes;
    int lo    = beat % 4;
    int hi    = ((beat & ~(bytes - 1)) % 4) + bytes - 1;
    logic [3:0] m = '0;
    for (int n = 0; n < 4; n++) m[n] = (n >= lo) && (n <= hi);
    return m;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic sendAw(int addr, int size, int len, logic [1:0] kind);
    awAddr = 32'(addr); awSize = 3'(size); awLen = 8'(len); awBurst = kind;
    awValid = 1'b1;
    @(negedge clk);
    awValid = 1'b0;
  endtask

  task automatic sendBeat(logic [3:0] strb, logic last, logic [3:0] expLanes,
                          logic eS, logic eL, string tag);
    expItem_t it;
    check({tag, " lanes"}, legalLanes, expLanes);
    it.expStrb = eS; it.expLast = eL; it.tag = tag;
    sbQ.push_back(it);
    wStrb = strb; wLast = last; wValid = 1'b1;
    @(negedge clk);
    wValid = 1'b0; wLast = 1'b0; wStrb = '0;
  endtask

  // Monitor: pops one expectation per accepted beat
  initial begin
    forever begin
      logic fired;
      expItem_t it;
      @(posedge clk);
      fired = wValid && wReady;
      @(negedge clk);
      if (fired && sbQ.size() > 0) begin
        it = sbQ.pop_front();
        check({it.tag, " strbErr"}, {3'b0, strbErr}, {3'b0, it.expStrb});
        check({it.tag, " lastErr"}, {3'b0, lastErr}, {3'b0, it.expLast});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 strbErr", {3'b0, strbErr}, 4'b0);
    check("R1 lastErr", {3'b0, lastErr}, 4'b0);
    check("R1 lanes", legalLanes, 4'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 lanes after release", legalLanes, 4'b0);

    // R2 R3 R5: start 0x09 size 2, four beats
    sendAw(9, 2, 3, 2'b01);
    sendBeat(4'b1110, 0, laneWin(9, 2, 0), 0, 0, "R2 first beat");
    sendBeat(4'b1111, 0, laneWin(9, 2, 1), 0, 0, "R3 beat1");
    sendBeat(4'b0101, 0, laneWin(9, 2, 2), 0, 0, "R5 subset");
    sendBeat(4'b0000, 1, laneWin(9, 2, 3), 0, 0, "R5 empty strobe");

    // R4: low lane enabled on a 0x09 start
    sendAw(9, 2, 0, 2'b01);
    sendBeat(4'b0111, 1, 4'b1110, 1, 0, "R4 low lane set");

    // R3 R4 R6 R7: size 1 from 0x09
    sendAw(9, 1, 3, 2'b01);
    sendBeat(4'b0010, 0, laneWin(9, 1, 0), 0, 0, "R3 half beat0");
    sendBeat(4'b0110, 0, laneWin(9, 1, 1), 1, 0, "R4 half outside");
    sendBeat(4'b0011, 1, laneWin(9, 1, 2), 0, 1, "R6 early last");
    sendBeat(4'b1100, 0, laneWin(9, 1, 3), 0, 1, "R7 missing last");
    check("R7 closed", legalLanes, 4'b0);

    // R8: second address phase while open is ignored
    sendAw(0, 2, 1, 2'b01);
    sendBeat(4'b1111, 0, 4'b1111, 0, 0, "R8 beat0");
    sendAw(3, 0, 0, 2'b01);
    sendBeat(4'b1111, 1, 4'b1111, 0, 0, "R8 beat1 unchanged");
    check("R8 closed", legalLanes, 4'b0);

    // R9: non-incrementing burst opens nothing; idle beats quiet
    sendAw(4, 2, 0, 2'b10);
    check("R9 no open", legalLanes, 4'b0);
    sendBeat(4'b1111, 1, 4'b0000, 0, 0, "R9 idle beat");
    sendBeat(4'b0001, 0, 4'b0000, 0, 0, "R9 idle beat2");

    // R10: size 0 walking lane
    sendAw(2, 0, 2, 2'b01);
    sendBeat(4'b0100, 0, laneWin(2, 0, 0), 0, 0, "R10 beat0");
    sendBeat(4'b1000, 0, laneWin(2, 0, 1), 0, 0, "R10 beat1");
    sendBeat(4'b0010, 1, laneWin(2, 0, 2), 1, 0, "R10 wrong lane");
    check("R10 closed", legalLanes, 4'b0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule